// File: doc/BRIEF.md
# I3C Controller Bit Timer

This block shapes the clock and data lines of an I3C active controller, one bus symbol at a time. The system clock runs many times faster than the bus clock, so every part of the waveform is a whole number of system clock cycles. The parts are SCL high and low, data setup and hold, rise and fall allowance, and START hold and repeated-START/STOP setup. Each count comes from a timing input.

A framing layer above the block asks for one symbol at a time over a valid/ready handshake. The symbol is a START, a data bit, a repeated START or a STOP. For each symbol the caller picks open-drain or push-pull timing, so both kinds can be mixed inside one frame. When the symbol is finished the block pulses a done flag. For a data bit it also returns the SDA level it captured.

The timing inputs are copied into the block when a START is accepted. The copy stays in use until the matching STOP. A count of zero behaves as one cycle. SCL is driven push-pull. SDA is given as a drive value and an enable, and the incoming SDA passes through a synchronizer before it is captured.

Top module: `i3c_bit_timer`

## Requirements
- R1: During and after reset, with no request, scl_o=1, sda_oe_o=0, sda_o=1, req_ready_o=1 and done_o=0.
- R2: Cycle 0 is the first cycle after the accepting clock edge. A START accepted on an idle bus drives SDA low (sda_oe_o=1, sda_o=0) in cycle 0 with SCL still high. SCL falls and done_o pulses in cycle HS, where HS is the START hold count.
- R3: For a data bit, SCL stays low for L = max(LOW, FALL+HOLD+SETUP) cycles starting at cycle 0. The SDA outputs keep their previous values until cycle FALL+HOLD, where they take the new bit.
- R4: For a data bit, SCL is high from cycle L for H = max(HIGH, RISE+1) cycles. SCL falls and done_o pulses in cycle L+H.
- R5: With done_o for a data bit, rd_bit_o equals the synchronized SDA level sampled in the last SCL-high cycle.
- R6: An open-drain bit of 0 gives sda_oe_o=1 and sda_o=0. An open-drain bit of 1 releases the line (sda_oe_o=0). A push-pull bit gives sda_oe_o=1 and sda_o equal to the bit.
- R7: req_od_i=1 selects the open-drain HIGH/LOW counts and req_od_i=0 selects the push-pull ones, chosen per symbol.
- R8: A repeated START releases SDA at cycle FALL+HOLD. It raises SCL at cycle max(LOW, FALL+HOLD+1), then waits max(START setup, RISE+1) cycles. It then pulls SDA low, holds for HS cycles, and drops SCL with done_o.
- R9: A STOP pulls SDA low at cycle FALL+HOLD and raises SCL at cycle max(LOW, FALL+HOLD+SETUP). After max(STOP setup, RISE+1) further cycles it releases SDA with done_o, leaving SCL high and the bus idle.
- R10: Any timing count of zero acts as one cycle.
- R11: Timing inputs are copied when a START is accepted. Changes to them take effect only at the next START after a STOP.
- R12: A START while a transfer is open, or any other symbol on an idle bus, is consumed with done_o in cycle 0 and no change on SCL or SDA.
- R13: req_ready_o is low from cycle 0 until the cycle done_o pulses, and done_o pulses once per accepted request. The symbol encoding is START=0, bit=1, repeated START=2, STOP=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Symbol request valid |
| req_ready_o | output | 1 | Ready to accept a symbol |
| req_sym_i | input | 2 | Symbol: 0 START, 1 bit, 2 repeated START, 3 STOP |
| req_bit_i | input | 1 | Data bit to send |
| req_od_i | input | 1 | 1 selects open-drain timing and driving |
| done_o | output | 1 | One-cycle pulse when a symbol finishes |
| rd_bit_o | output | 1 | Captured SDA level of the last data bit |
| tm_hi_pp_i | input | CW | SCL high count, push-pull |
| tm_lo_pp_i | input | CW | SCL low count, push-pull |
| tm_hi_od_i | input | CW | SCL high count, open-drain |
| tm_lo_od_i | input | CW | SCL low count, open-drain |
| tm_su_dat_i | input | CW | Data setup count |
| tm_hd_dat_i | input | CW | Data hold count |
| tm_rise_i | input | CW | Rise allowance count |
| tm_fall_i | input | CW | Fall allowance count |
| tm_hd_sta_i | input | CW | START hold count |
| tm_su_sta_i | input | CW | Repeated START setup count |
| tm_su_sto_i | input | CW | STOP setup count |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_o | output | 1 | SCL output |
| sda_o | output | 1 | SDA drive value |
| sda_oe_o | output | 1 | SDA drive enable |

## Verification
The hardest case to reach from the ports is a timing change in the middle of an open transfer. Its effect must be held back until a STOP and a new START, and nothing in a single symbol reveals whether the copy was taken. The stimulus opens a transfer with one timing set and rewrites the inputs between symbols. It shows that the following bit still uses the old lengths, then closes the transfer and shows the new lengths after the next START. Illegal requests get similar treatment: a START is sent into an open transfer and a STOP and a bit onto an idle bus, and the bench checks that only a done pulse results.

// File: rtl/i3cbt_pkg.sv
package i3cbt_pkg;

   typedef enum logic [1:0] {
      SYM_START  = 2'd0,
      SYM_BIT    = 2'd1,
      SYM_RSTART = 2'd2,
      SYM_STOP   = 2'd3
   } sym_e;

   typedef enum logic [2:0] {
      S_WAIT,
      S_ST_HOLD,
      S_LOW,
      S_HIGH,
      S_RS_SU,
      S_RS_HOLD,
      S_SP_SU
   } st_e;

   // positions of the timing fields in the packed timing vector
   localparam int TI_HI_PP  = 0;
   localparam int TI_LO_PP  = 1;
   localparam int TI_HI_OD  = 2;
   localparam int TI_LO_OD  = 3;
   localparam int TI_SU_DAT = 4;
   localparam int TI_HD_DAT = 5;
   localparam int TI_RISE   = 6;
   localparam int TI_FALL   = 7;
   localparam int TI_HD_STA = 8;
   localparam int TI_SU_STA = 9;
   localparam int TI_SU_STO = 10;
   localparam int NT        = 11;

endpackage

// File: rtl/i3cbt_sync.sv
module i3cbt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] ff;

   if (STAGES < 2) begin : g_bad_depth
      $error("i3cbt_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) ff[i] <= 1'b1;
            else         ff[i] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) ff[i] <= 1'b1;
            else         ff[i] <= ff[i-1];
         end
      end
   end

   assign q_o = ff[STAGES-1];
endmodule

// File: rtl/i3cbt_tcfg.sv
module i3cbt_tcfg #(
   parameter int CW = 8,
   parameter int NF = 11
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   load_i,
   input  logic [NF-1:0][CW-1:0]  raw_i,
   output logic [NF-1:0][CW-1:0]  eff_o
);
   for (genvar i = 0; i < NF; i++) begin : g_field
      logic [CW-1:0] held;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     held <= '0;
         else if (load_i) held <= raw_i[i];
      end
      // a zero count still lasts one cycle
      assign eff_o[i] = (held == '0) ? CW'(1) : held;
   end
endmodule

// File: rtl/i3cbt_seq.sv
module i3cbt_seq
   import i3cbt_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  req_valid_i,
   input  logic [1:0]            req_sym_i,
   input  logic                  req_bit_i,
   input  logic                  req_od_i,
   input  logic [NT-1:0][CW-1:0] eff_i,
   input  logic                  sda_s_i,
   output logic                  req_ready_o,
   output logic                  done_o,
   output logic                  rd_bit_o,
   output logic                  scl_o,
   output logic                  sda_o,
   output logic                  sda_oe_o,
   output logic                  load_o
);
   localparam int DW = CW + 2;

   function automatic logic [DW-1:0] mx(input logic [DW-1:0] a, input logic [DW-1:0] b);
      return (a > b) ? a : b;
   endfunction

   st_e            state;
   sym_e           sym_q;
   logic           mode_q, bit_q, busy_q;
   logic [DW-1:0]  cnt;

   logic [DW-1:0]  lo, hi, hold_pt, rise1, low_len, high_len;
   logic [DW-1:0]  sta_su_len, sto_su_len, hs_len;
   logic           legal;

   always_comb begin
      lo         = mode_q ? DW'(eff_i[TI_LO_OD]) : DW'(eff_i[TI_LO_PP]);
      hi         = mode_q ? DW'(eff_i[TI_HI_OD]) : DW'(eff_i[TI_HI_PP]);
      hold_pt    = DW'(eff_i[TI_FALL]) + DW'(eff_i[TI_HD_DAT]);
      rise1      = DW'(eff_i[TI_RISE]) + DW'(1);
      low_len    = (sym_q == SYM_RSTART) ? mx(lo, hold_pt + DW'(1))
                                         : mx(lo, hold_pt + DW'(eff_i[TI_SU_DAT]));
      high_len   = mx(hi, rise1);
      sta_su_len = mx(DW'(eff_i[TI_SU_STA]), rise1);
      sto_su_len = mx(DW'(eff_i[TI_SU_STO]), rise1);
      hs_len     = DW'(eff_i[TI_HD_STA]);
   end

   assign legal       = (req_sym_i == SYM_START) ? !busy_q : busy_q;
   assign req_ready_o = (state == S_WAIT);
   assign load_o      = req_valid_i && req_ready_o && legal && (req_sym_i == SYM_START);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state    <= S_WAIT;
         sym_q    <= SYM_START;
         mode_q   <= 1'b0;
         bit_q    <= 1'b0;
         busy_q   <= 1'b0;
         cnt      <= '0;
         scl_o    <= 1'b1;
         sda_o    <= 1'b1;
         sda_oe_o <= 1'b0;
         done_o   <= 1'b0;
         rd_bit_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state)
            S_WAIT: begin
               if (req_valid_i) begin
                  if (!legal) begin
                     done_o <= 1'b1;
                  end else begin
                     sym_q  <= sym_e'(req_sym_i);
                     mode_q <= req_od_i;
                     bit_q  <= req_bit_i;
                     cnt    <= '0;
                     if (req_sym_i == SYM_START) begin
                        busy_q   <= 1'b1;
                        sda_oe_o <= 1'b1;
                        sda_o    <= 1'b0;
                        state    <= S_ST_HOLD;
                     end else begin
                        state <= S_LOW;
                     end
                  end
               end
            end
            S_ST_HOLD, S_RS_HOLD: begin
               if (cnt == hs_len - DW'(1)) begin
                  scl_o  <= 1'b0;
                  done_o <= 1'b1;
                  state  <= S_WAIT;
               end else begin
                  cnt <= cnt + DW'(1);
               end
            end
            S_LOW: begin
               if (cnt == low_len - DW'(1)) begin
                  scl_o <= 1'b1;
                  cnt   <= '0;
                  case (sym_q)
                     SYM_BIT:    state <= S_HIGH;
                     SYM_RSTART: state <= S_RS_SU;
                     default:    state <= S_SP_SU;
                  endcase
               end else begin
                  cnt <= cnt + DW'(1);
                  if (cnt == hold_pt - DW'(1)) begin
                     case (sym_q)
                        SYM_BIT: begin
                           sda_o    <= bit_q;
                           sda_oe_o <= mode_q ? !bit_q : 1'b1;
                        end
                        SYM_RSTART: begin
                           sda_o    <= 1'b1;
                           sda_oe_o <= 1'b0;
                        end
                        default: begin
                           sda_o    <= 1'b0;
                           sda_oe_o <= 1'b1;
                        end
                     endcase
                  end
               end
            end
            S_HIGH: begin
               if (cnt == high_len - DW'(1)) begin
                  rd_bit_o <= sda_s_i;
                  scl_o    <= 1'b0;
                  done_o   <= 1'b1;
                  state    <= S_WAIT;
               end else begin
                  cnt <= cnt + DW'(1);
               end
            end
            S_RS_SU: begin
               if (cnt == sta_su_len - DW'(1)) begin
                  sda_oe_o <= 1'b1;
                  sda_o    <= 1'b0;
                  cnt      <= '0;
                  state    <= S_RS_HOLD;
               end else begin
                  cnt <= cnt + DW'(1);
               end
            end
            S_SP_SU: begin
               if (cnt == sto_su_len - DW'(1)) begin
                  sda_oe_o <= 1'b0;
                  sda_o    <= 1'b1;
                  done_o   <= 1'b1;
                  busy_q   <= 1'b0;
                  state    <= S_WAIT;
               end else begin
                  cnt <= cnt + DW'(1);
               end
            end
            default: state <= S_WAIT;
         endcase
      end
   end
endmodule

// File: rtl/i3c_bit_timer.sv
module i3c_bit_timer
   import i3cbt_pkg::*;
#(
   parameter int CW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          req_valid_i,
   output logic          req_ready_o,
   input  logic [1:0]    req_sym_i,
   input  logic          req_bit_i,
   input  logic          req_od_i,
   output logic          done_o,
   output logic          rd_bit_o,
   input  logic [CW-1:0] tm_hi_pp_i,
   input  logic [CW-1:0] tm_lo_pp_i,
   input  logic [CW-1:0] tm_hi_od_i,
   input  logic [CW-1:0] tm_lo_od_i,
   input  logic [CW-1:0] tm_su_dat_i,
   input  logic [CW-1:0] tm_hd_dat_i,
   input  logic [CW-1:0] tm_rise_i,
   input  logic [CW-1:0] tm_fall_i,
   input  logic [CW-1:0] tm_hd_sta_i,
   input  logic [CW-1:0] tm_su_sta_i,
   input  logic [CW-1:0] tm_su_sto_i,
   input  logic          sda_i,
   output logic          scl_o,
   output logic          sda_o,
   output logic          sda_oe_o
);
   if (CW < 3) begin : g_bad_width
      $error("i3c_bit_timer: CW must be at least 3");
   end

   logic [NT-1:0][CW-1:0] raw, eff;
   logic                  load, sda_s;

   assign raw[TI_HI_PP]  = tm_hi_pp_i;
   assign raw[TI_LO_PP]  = tm_lo_pp_i;
   assign raw[TI_HI_OD]  = tm_hi_od_i;
   assign raw[TI_LO_OD]  = tm_lo_od_i;
   assign raw[TI_SU_DAT] = tm_su_dat_i;
   assign raw[TI_HD_DAT] = tm_hd_dat_i;
   assign raw[TI_RISE]   = tm_rise_i;
   assign raw[TI_FALL]   = tm_fall_i;
   assign raw[TI_HD_STA] = tm_hd_sta_i;
   assign raw[TI_SU_STA] = tm_su_sta_i;
   assign raw[TI_SU_STO] = tm_su_sto_i;

   i3cbt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (sda_i),
      .q_o    (sda_s)
   );

   i3cbt_tcfg #(.CW(CW), .NF(NT)) u_tcfg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .raw_i  (raw),
      .eff_o  (eff)
   );

   i3cbt_seq #(.CW(CW)) u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_valid_i (req_valid_i),
      .req_sym_i   (req_sym_i),
      .req_bit_i   (req_bit_i),
      .req_od_i    (req_od_i),
      .eff_i       (eff),
      .sda_s_i     (sda_s),
      .req_ready_o (req_ready_o),
      .done_o      (done_o),
      .rd_bit_o    (rd_bit_o),
      .scl_o       (scl_o),
      .sda_o       (sda_o),
      .sda_oe_o    (sda_oe_o),
      .load_o      (load)
   );
endmodule

// File: rtl/i3cbt_chk.sv
module i3cbt_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic [1:0] req_sym,
   input logic       done,
   input logic       scl,
   input logic       sda_o,
   input logic       sda_oe
);
   logic [1:0] cur_sym;
   logic       cur_legal, busy_m, acc_legal;

   assign acc_legal = (req_sym == 2'd0) ? !busy_m : busy_m;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_sym   <= 2'd0;
         cur_legal <= 1'b0;
         busy_m    <= 1'b0;
      end else if (req_valid && req_ready) begin
         cur_sym   <= req_sym;
         cur_legal <= acc_legal;
         if (acc_legal && req_sym == 2'd0) busy_m <= 1'b1;
         if (acc_legal && req_sym == 2'd3) busy_m <= 1'b0;
      end
   end

   p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_m && req_ready) |-> (scl && !sda_oe));

   p_start_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cur_legal && cur_sym == 2'd0) |-> (!scl && sda_oe && !sda_o));

   p_sda_quiet_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_sym == 2'd1 && !req_ready && scl && $past(scl)) |-> ($stable(sda_oe) && $stable(sda_o)));

   p_stop_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cur_legal && cur_sym == 2'd3) |-> (scl && !sda_oe));

   p_scl_only_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(scl) |-> !$past(req_ready));

   p_done_ready_r13: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);
endmodule

bind i3c_bit_timer i3cbt_chk u_chk (
   .clk       (clk_i),
   .rst_n     (rst_ni),
   .req_valid (req_valid_i),
   .req_ready (req_ready_o),
   .req_sym   (req_sym_i),
   .done      (done_o),
   .scl       (scl_o),
   .sda_o     (sda_o),
   .sda_oe    (sda_oe_o)
);

// File: tb/i3c_bit_timer_test.sv
module i3c_bit_timer_test;
   import i3cbt_pkg::*;

   localparam int CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic          req_valid = 1'b0;
   logic [1:0]    req_sym = 2'd0;
   logic          req_bit = 1'b0;
   logic          req_od = 1'b0;
   logic          ready, done, rd_bit, scl, sda_o, sda_oe;
   logic [CW-1:0] tm [NT];
   logic [CW-1:0] lt [NT];
   logic          tgt_sda = 1'b1;
   logic          sda_line;

   assign sda_line = (sda_oe ? sda_o : 1'b1) & tgt_sda;

   i3c_bit_timer #(.CW(CW), .SYNC_STAGES(2)) uut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_valid_i (req_valid),
      .req_ready_o (ready),
      .req_sym_i   (req_sym),
      .req_bit_i   (req_bit),
      .req_od_i    (req_od),
      .done_o      (done),
      .rd_bit_o    (rd_bit),
      .tm_hi_pp_i  (tm[TI_HI_PP]),
      .tm_lo_pp_i  (tm[TI_LO_PP]),
      .tm_hi_od_i  (tm[TI_HI_OD]),
      .tm_lo_od_i  (tm[TI_LO_OD]),
      .tm_su_dat_i (tm[TI_SU_DAT]),
      .tm_hd_dat_i (tm[TI_HD_DAT]),
      .tm_rise_i   (tm[TI_RISE]),
      .tm_fall_i   (tm[TI_FALL]),
      .tm_hd_sta_i (tm[TI_HD_STA]),
      .tm_su_sta_i (tm[TI_SU_STA]),
      .tm_su_sto_i (tm[TI_SU_STO]),
      .sda_i       (sda_line),
      .scl_o       (scl),
      .sda_o       (sda_o),
      .sda_oe_o    (sda_oe)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit tb_busy = 1'b0;
   bit fin = 1'b0;

   typedef struct {
      int    cy;
      bit    has_rd;
      bit    rd;
      string req;
   } exp_t;
   exp_t q[$];

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   function automatic int ev(input int idx);
      return (lt[idx] == 0) ? 1 : int'(lt[idx]);
   endfunction

   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic at(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic set_tm(input int hpp, input int lpp, input int hod, input int lod,
                         input int su, input int hd, input int ri, input int fa,
                         input int hs, input int ssta, input int ssto);
      tm[TI_HI_PP] = CW'(hpp);  tm[TI_LO_PP] = CW'(lpp);
      tm[TI_HI_OD] = CW'(hod);  tm[TI_LO_OD] = CW'(lod);
      tm[TI_SU_DAT] = CW'(su);  tm[TI_HD_DAT] = CW'(hd);
      tm[TI_RISE] = CW'(ri);    tm[TI_FALL] = CW'(fa);
      tm[TI_HD_STA] = CW'(hs);  tm[TI_SU_STA] = CW'(ssta);
      tm[TI_SU_STO] = CW'(ssto);
   endtask

   // monitor: pops expected completions as done pulses appear
   always @(negedge clk) begin
      exp_t e;
      if (rst_n && done) begin
         if (q.size() == 0) begin
            chk("R13", "done with nothing pending", 1, 0);
         end else begin
            e = q.pop_front();
            chk(e.req, "done cycle", cyc, e.cy);
            if (e.has_rd) chk("R5", "captured bit", int'(rd_bit), int'(e.rd));
         end
      end
   end

   // driver: sends one symbol, queues its completion and checks the waveform
   task automatic send(input sym_e s, input bit b, input bit od, input string tag);
      int  c0, hp, lo, hi, r1, L, H, S, HS, D;
      bit  legal, poe, po, pscl;
      string lt_tag;
      while (!ready) @(negedge clk);
      legal = (s == SYM_START) ? !tb_busy : tb_busy;
      if (legal && s == SYM_START) lt = tm;
      lo = od ? ev(TI_LO_OD) : ev(TI_LO_PP);
      hi = od ? ev(TI_HI_OD) : ev(TI_HI_PP);
      hp = ev(TI_FALL) + ev(TI_HD_DAT);
      r1 = ev(TI_RISE) + 1;
      HS = ev(TI_HD_STA);
      L = 0; H = 0; S = 0; D = 0;
      if (legal) begin
         case (s)
            SYM_START:  D = HS;
            SYM_BIT:    begin L = mx(lo, hp + ev(TI_SU_DAT)); H = mx(hi, r1); D = L + H; end
            SYM_RSTART: begin L = mx(lo, hp + 1); S = mx(ev(TI_SU_STA), r1); D = L + S + HS; end
            default:    begin L = mx(lo, hp + ev(TI_SU_DAT)); S = mx(ev(TI_SU_STO), r1); D = L + S; end
         endcase
      end
      lt_tag = od ? "R7" : "R3";
      c0 = cyc + 1;
      poe = sda_oe; po = sda_o; pscl = scl;
      q.push_back('{c0 + D, legal && (s == SYM_BIT), b & tgt_sda, tag});
      req_valid = 1'b1; req_sym = s; req_bit = b; req_od = od;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (!legal) begin
         chk("R12", "scl after refused symbol", int'(scl), int'(pscl));
         chk("R12", "sda_oe after refused symbol", int'(sda_oe), int'(poe));
         chk("R12", "ready after refused symbol", int'(ready), 1);
         return;
      end
      chk("R13", "ready during symbol", int'(ready), 0);
      case (s)
         SYM_START: begin
            chk("R2", "scl high at start", int'(scl), 1);
            chk("R2", "sda pulled at start", int'({sda_oe, sda_o}), 2);
            at(c0 + HS - 1); chk("R2", "scl before hold end", int'(scl), 1);
            at(c0 + HS);     chk("R2", "scl after hold", int'(scl), 0);
            tb_busy = 1'b1;
         end
         SYM_BIT: begin
            at(c0 + hp - 1); chk("R3", "sda held before hold point", int'({sda_oe, sda_o}), int'({poe, po}));
            at(c0 + hp);
            if (od) chk("R6", "open-drain encoding", int'({sda_oe, sda_o}), b ? 1 : 2);
            else    chk("R6", "push-pull encoding", int'({sda_oe, sda_o}), b ? 3 : 2);
            at(c0 + L - 1);     chk(lt_tag, "scl low end", int'(scl), 0);
            at(c0 + L);         chk(lt_tag, "scl rises", int'(scl), 1);
            at(c0 + L + H - 1); chk("R4", "scl high end", int'(scl), 1);
                                chk("R13", "ready before done", int'(ready), 0);
            at(c0 + L + H);     chk("R4", "scl falls", int'(scl), 0);
                                chk("R13", "ready at done", int'(ready), 1);
         end
         SYM_RSTART: begin
            at(c0 + hp);         chk("R8", "sda released", int'(sda_oe), 0);
            at(c0 + L - 1);      chk("R8", "scl low end", int'(scl), 0);
            at(c0 + L);          chk("R8", "scl rises", int'(scl), 1);
            at(c0 + L + S - 1);  chk("R8", "sda still released", int'(sda_oe), 0);
            at(c0 + L + S);      chk("R8", "sda pulled with scl high", int'({scl, sda_oe, sda_o}), 6);
            at(c0 + D - 1);      chk("R8", "scl before hold end", int'(scl), 1);
            at(c0 + D);          chk("R8", "scl after hold", int'(scl), 0);
         end
         default: begin
            at(c0 + hp);         chk("R9", "sda pulled low", int'({sda_oe, sda_o}), 2);
            at(c0 + L - 1);      chk("R9", "scl low end", int'(scl), 0);
            at(c0 + L);          chk("R9", "scl rises", int'(scl), 1);
            at(c0 + L + S - 1);  chk("R9", "sda held before stop", int'(sda_oe), 1);
            at(c0 + L + S);      chk("R9", "bus idle after stop", int'({scl, sda_oe}), 2);
            tb_busy = 1'b0;
         end
      endcase
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      set_tm(20, 20, 20, 60, 3, 2, 6, 6, 20, 20, 20);
      repeat (3) @(negedge clk);
      chk("R1", "reset lines", int'({scl, sda_oe, sda_o}), 5);
      chk("R1", "reset handshake", int'({ready, done}), 2);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "idle lines", int'({scl, sda_oe, sda_o}), 5);

      // refused symbols on an idle bus
      send(SYM_STOP, 1'b0, 1'b0, "R12");
      send(SYM_BIT, 1'b1, 1'b0, "R12");

      // a mixed frame with default timing
      send(SYM_START, 1'b0, 1'b1, "R2");
      send(SYM_START, 1'b0, 1'b1, "R12");
      tgt_sda = 1'b1;
      send(SYM_BIT, 1'b1, 1'b0, "R4");
      send(SYM_BIT, 1'b0, 1'b0, "R4");
      tgt_sda = 1'b0;
      send(SYM_BIT, 1'b1, 1'b1, "R7");
      tgt_sda = 1'b1;
      send(SYM_BIT, 1'b0, 1'b1, "R7");
      send(SYM_RSTART, 1'b0, 1'b1, "R8");
      send(SYM_BIT, 1'b1, 1'b1, "R5");
      send(SYM_STOP, 1'b0, 1'b0, "R9");

      // timing copy held through an open transfer
      send(SYM_START, 1'b0, 1'b0, "R11");
      set_tm(3, 4, 5, 9, 3, 2, 6, 6, 7, 8, 9);
      send(SYM_BIT, 1'b1, 1'b0, "R11");
      send(SYM_STOP, 1'b0, 1'b0, "R11");
      send(SYM_START, 1'b0, 1'b0, "R11");
      send(SYM_BIT, 1'b0, 1'b0, "R11");
      send(SYM_RSTART, 1'b0, 1'b0, "R11");
      send(SYM_STOP, 1'b0, 1'b0, "R11");

      // all counts zero
      set_tm(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      send(SYM_START, 1'b0, 1'b0, "R10");
      send(SYM_BIT, 1'b1, 1'b0, "R10");
      send(SYM_BIT, 1'b0, 1'b1, "R10");
      send(SYM_RSTART, 1'b0, 1'b0, "R10");
      send(SYM_STOP, 1'b0, 1'b0, "R10");

      repeat (5) @(negedge clk);
      chk("R13", "pending completions", q.size(), 0);
      chk("R9", "final idle lines", int'({scl, sda_oe}), 2);
      fin = 1'b1;
      summary();
      $finish;
   end
endmodule